// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the transmit and receive queues of an SPI controller and reports on them. Software writes words into the transmit queue and reads words out of the receive queue through a small word-addressed register bus; the serial engine on the far side pops transmit words and pushes received words through single-cycle strobes. The bus read data is combinational: it is valid in the same cycle as the address. A read of the receive data port removes the head entry at the next clock edge.

Around the two queues the unit keeps fill levels, a five-bit status word, threshold-driven interrupt sources, three sticky error flags with a separate clear register, a mask with a masked view and a single interrupt line, and two DMA request outputs driven by their own level registers. Every level-type register accepts a new value only when that value is below the queue depth. This lets software find the depth by writing ever larger values and reading back.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: Reset is synchronous and active low. After reset both fill levels read 0, status reads 0x0C, raw interrupts read 0x01, and mask, DMA control and all level registers read 0. The irq, dma_tx_req and dma_rx_req outputs are low.
- R2: The word addresses are: 0x0 transmit data (write), 0x1 receive data (read and pop), 0x2 transmit level, 0x3 receive level, 0x4 status, 0x5 transmit threshold, 0x6 receive threshold, 0x7 mask, 0x8 raw interrupts, 0x9 masked interrupts, 0xA clear (write), 0xB DMA control, 0xC transmit DMA level, 0xD receive DMA level. Both queues are first-in first-out, and each level register reports the number of entries held.
- R3: The status bits are: bit 0 follows eng_busy, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full.
- R4: A bus write to a full transmit queue discards the word and sets raw bit 1 (transmit overflow). The bit stays set until it is cleared.
- R5: A read of the receive data port while the receive queue is empty returns 0 and sets raw bit 2 (receive underflow). The bit is sticky.
- R6: An engine push into a full receive queue discards the word and sets raw bit 3 (receive overflow). The bit is sticky.
- R7: Raw bit 0 is high while the transmit level is at or below the transmit threshold. Raw bit 4 is high while the receive level is above the receive threshold.
- R8: The two threshold registers and the two DMA level registers take a written value only if it is less than DEPTH. Otherwise they keep their previous value.
- R9: The masked register equals raw AND mask (bit for bit on the raw layout), and irq is high when any masked bit is set.
- R10: A write to the clear register acts per bit: bit 0 clears all three sticky flags, bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow. Threshold bits are not affected.
- R11: DMA control bit 0 enables dma_rx_req, which is high while the receive level is above the receive DMA level. Bit 1 enables dma_tx_req, which is high while the transmit level is at or below the transmit DMA level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at receive data address) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| eng_busy | input | 1 | Serial engine activity, shown in status bit 0 |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_data | output | DW | Transmit head word, 0 when empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| irq | output | 1 | OR of the masked interrupt bits |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that the bus strobes and engine strobes are clean single-cycle levels sampled at the rising edge. They also assume that a clear write never lands in the same cycle as a fresh error event on the flag it targets, because a new event takes priority over the clear. The bench drives every strobe on the falling edge and issues at most one bus access per cycle. It never combines a clear with an overflow or underflow, so each sticky flag is checked only in cycles where its set and clear causes are separated.

// File: rtl/spi_fifo_pkg.sv
// Shared constants for the SPI FIFO status and interrupt unit: the word
// address map, the bit positions of the status, interrupt, clear and DMA
// control words, and the error event bundle passed between modules.
package spi_fifo_pkg;

    localparam int ADDR_W = 4;
    localparam int IRQ_W  = 5;
    localparam int CLR_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_TXDATA = 4'h0,
        A_RXDATA = 4'h1,
        A_TXLVL  = 4'h2,
        A_RXLVL  = 4'h3,
        A_STATUS = 4'h4,
        A_TXTHR  = 4'h5,
        A_RXTHR  = 4'h6,
        A_MASK   = 4'h7,
        A_RAW    = 4'h8,
        A_MASKED = 4'h9,
        A_CLEAR  = 4'hA,
        A_DMACTL = 4'hB,
        A_DMATX  = 4'hC,
        A_DMARX  = 4'hD
    } reg_addr_e;

    // Interrupt bit positions (raw, mask and masked share this layout)
    localparam int IRQ_TXE = 0;
    localparam int IRQ_TXO = 1;
    localparam int IRQ_RXU = 2;
    localparam int IRQ_RXO = 3;
    localparam int IRQ_RXF = 4;

    // Clear register bit positions
    localparam int CLR_ALL = 0;
    localparam int CLR_RXU = 1;
    localparam int CLR_RXO = 2;
    localparam int CLR_TXO = 3;

    // Status bit positions
    localparam int ST_BUSY = 0;
    localparam int ST_TXF  = 1;
    localparam int ST_TXE  = 2;
    localparam int ST_RXE  = 3;
    localparam int ST_RXF  = 4;

    // DMA control bit positions
    localparam int DMA_RX_EN = 0;
    localparam int DMA_TX_EN = 1;

    typedef struct packed {
        logic txo;
        logic rxu;
        logic rxo;
    } err_evt_t;

endpackage

// File: rtl/spi_fifo_store.sv
// Synchronous first-in first-out queue with a live fill level.
// Assumes DEPTH >= 2. A push while full and a pop while empty are dropped and
// reported through push_drop / pop_miss for one cycle. head shows the oldest
// entry and reads 0 when the queue is empty.
module spi_fifo_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LVLW-1:0]  level,
    output logic             full,
    output logic             empty,
    output logic             push_drop,
    output logic             pop_miss
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTRW-1:0]  wr_ptr;
    logic [PTRW-1:0]  rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full      = (level == LVLW'(DEPTH));
    assign empty     = (level == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_drop = push && full;
    assign pop_miss  = pop && empty;
    assign head      = empty ? '0 : mem[rd_ptr];

    // Storage write for accepted pushes
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer advance with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Fill level tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   level <= level + LVLW'(1);
                2'b01:   level <= level - LVLW'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/spi_fifo_cfg.sv
// Software-writable configuration: two interrupt thresholds, two DMA levels,
// interrupt mask and DMA enables, plus decode of the clear register write.
// Level-type registers accept a write only when the value is below DEPTH.
// Assumes one bus access per cycle.
module spi_fifo_cfg
    import spi_fifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [LVLW-1:0]   tx_thr,
    output logic [LVLW-1:0]   rx_thr,
    output logic [LVLW-1:0]   dma_tx_lvl,
    output logic [LVLW-1:0]   dma_rx_lvl,
    output logic [IRQ_W-1:0]  irq_mask,
    output logic [1:0]        dma_en,
    output logic [CLR_W-1:0]  clr
);

    localparam int NLVL = 4;
    localparam logic [ADDR_W-1:0] LVL_ADDR [NLVL] = '{A_TXTHR, A_RXTHR, A_DMATX, A_DMARX};

    logic [NLVL-1:0][LVLW-1:0] lvl_q;
    logic                      in_range;

    assign in_range = (wdata < DW'(DEPTH));

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        logic [LVLW-1:0] q;
        // Range-checked level register
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else if (wr_en && addr == LVL_ADDR[g] && in_range) q <= LVLW'(wdata);
        end
        assign lvl_q[g] = q;
    end

    assign tx_thr     = lvl_q[0];
    assign rx_thr     = lvl_q[1];
    assign dma_tx_lvl = lvl_q[2];
    assign dma_rx_lvl = lvl_q[3];

    // Mask and DMA enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_mask <= '0;
            dma_en   <= '0;
        end else if (wr_en) begin
            if (addr == A_MASK)   irq_mask <= wdata[IRQ_W-1:0];
            if (addr == A_DMACTL) dma_en   <= wdata[1:0];
        end
    end

    // Clear strobes are live only in the cycle of the clear write
    assign clr = (wr_en && addr == A_CLEAR) ? wdata[CLR_W-1:0] : '0;

endmodule

// File: rtl/spi_fifo_irq.sv
// Interrupt source logic: two level-driven threshold bits, three sticky
// error bits with per-bit clear, the masked view and the combined line.
// A new error event in the same cycle as its clear leaves the flag set.
module spi_fifo_irq
    import spi_fifo_pkg::*;
#(
    parameter int LVLW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVLW-1:0]  tx_lvl,
    input  logic [LVLW-1:0]  rx_lvl,
    input  logic [LVLW-1:0]  tx_thr,
    input  logic [LVLW-1:0]  rx_thr,
    input  logic [IRQ_W-1:0] irq_mask,
    input  err_evt_t         evt,
    input  logic [CLR_W-1:0] clr,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);

    err_evt_t sticky;
    err_evt_t wipe;

    // Per-flag clear: the all-bit plus the flag's own bit
    assign wipe.txo = clr[CLR_ALL] | clr[CLR_TXO];
    assign wipe.rxu = clr[CLR_ALL] | clr[CLR_RXU];
    assign wipe.rxo = clr[CLR_ALL] | clr[CLR_RXO];

    // Sticky error flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~wipe) | evt;
    end

    // Assemble the raw interrupt word
    always_comb begin
        raw          = '0;
        raw[IRQ_TXE] = (tx_lvl <= tx_thr);
        raw[IRQ_TXO] = sticky.txo;
        raw[IRQ_RXU] = sticky.rxu;
        raw[IRQ_RXO] = sticky.rxo;
        raw[IRQ_RXF] = (rx_lvl > rx_thr);
    end

    assign masked = raw & irq_mask;
    assign irq    = |masked;

endmodule

// File: rtl/spi_fifo_irq_unit.sv
// Top of the SPI FIFO status and interrupt unit. Connects the register bus
// and the serial engine strobes to a transmit and a receive queue, the
// configuration registers and the interrupt logic, and forms the read mux,
// status word and DMA requests. Assumes 2 <= DEPTH < 32 and DW >= 5.
module spi_fifo_irq_unit
    import spi_fifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_tx_pop,
    output logic [DW-1:0]     eng_tx_data,
    input  logic              eng_rx_push,
    input  logic [DW-1:0]     eng_rx_data,
    output logic              irq,
    output logic              dma_tx_req,
    output logic              dma_rx_req
);

    logic             tx_wr;
    logic             rx_rd;
    logic [LVLW-1:0]  tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_drop, tx_miss, rx_drop, rx_miss;
    logic [DW-1:0]    rx_head;
    logic [LVLW-1:0]  thr_tx, thr_rx, lvl_dtx, lvl_drx;
    logic [IRQ_W-1:0] irq_mask, irq_raw, irq_masked;
    logic [1:0]       dma_en;
    logic [CLR_W-1:0] clr;
    logic [4:0]       status;
    err_evt_t         evt;

    assign tx_wr = bus_wr && bus_addr == A_TXDATA;
    assign rx_rd = bus_rd && bus_addr == A_RXDATA;

    spi_fifo_store #(.WIDTH(DW), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_wr),
        .push_data (bus_wdata),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .level     (tx_lvl),
        .full      (tx_full),
        .empty     (tx_empty),
        .push_drop (tx_drop),
        .pop_miss  (tx_miss)
    );

    spi_fifo_store #(.WIDTH(DW), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_rd),
        .head      (rx_head),
        .level     (rx_lvl),
        .full      (rx_full),
        .empty     (rx_empty),
        .push_drop (rx_drop),
        .pop_miss  (rx_miss)
    );

    spi_fifo_cfg #(.DW(DW), .DEPTH(DEPTH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .tx_thr     (thr_tx),
        .rx_thr     (thr_rx),
        .dma_tx_lvl (lvl_dtx),
        .dma_rx_lvl (lvl_drx),
        .irq_mask   (irq_mask),
        .dma_en     (dma_en),
        .clr        (clr)
    );

    // Error events gathered from the two queues
    always_comb begin
        evt.txo = tx_drop;
        evt.rxu = rx_miss;
        evt.rxo = rx_drop;
    end

    spi_fifo_irq #(.LVLW(LVLW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_lvl   (tx_lvl),
        .rx_lvl   (rx_lvl),
        .tx_thr   (thr_tx),
        .rx_thr   (thr_rx),
        .irq_mask (irq_mask),
        .evt      (evt),
        .clr      (clr),
        .raw      (irq_raw),
        .masked   (irq_masked),
        .irq      (irq)
    );

    // Status word
    always_comb begin
        status          = '0;
        status[ST_BUSY] = eng_busy;
        status[ST_TXF]  = tx_full;
        status[ST_TXE]  = tx_empty;
        status[ST_RXE]  = rx_empty;
        status[ST_RXF]  = rx_full;
    end

    // DMA requests
    assign dma_tx_req = dma_en[DMA_TX_EN] && (tx_lvl <= lvl_dtx);
    assign dma_rx_req = dma_en[DMA_RX_EN] && (rx_lvl > lvl_drx);

    // Combinational read mux
    always_comb begin
        case (bus_addr)
            A_RXDATA: bus_rdata = rx_head;
            A_TXLVL:  bus_rdata = DW'(tx_lvl);
            A_RXLVL:  bus_rdata = DW'(rx_lvl);
            A_STATUS: bus_rdata = DW'(status);
            A_TXTHR:  bus_rdata = DW'(thr_tx);
            A_RXTHR:  bus_rdata = DW'(thr_rx);
            A_MASK:   bus_rdata = DW'(irq_mask);
            A_RAW:    bus_rdata = DW'(irq_raw);
            A_MASKED: bus_rdata = DW'(irq_masked);
            A_DMACTL: bus_rdata = DW'(dma_en);
            A_DMATX:  bus_rdata = DW'(lvl_dtx);
            A_DMARX:  bus_rdata = DW'(lvl_drx);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_irq_unit_checker.sv
// Property checker for spi_fifo_irq_unit, bound into every instance.
// Assumes single-cycle strobes and no clear write in the same cycle as an
// error event on the targeted flag.
module spi_fifo_irq_unit_checker
    import spi_fifo_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int LVLW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              eng_rx_push,
    input logic [LVLW-1:0]   tx_lvl,
    input logic [LVLW-1:0]   rx_lvl,
    input logic              tx_full,
    input logic              rx_full,
    input logic              rx_empty,
    input logic [IRQ_W-1:0]  irq_raw,
    input logic [LVLW-1:0]   thr_tx,
    input logic              irq,
    input logic              dma_rx_req
);

    logic clr_txo_hit;
    assign clr_txo_hit = bus_wr && bus_addr == A_CLEAR &&
                         (bus_wdata[CLR_ALL] || bus_wdata[CLR_TXO]);

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= LVLW'(DEPTH)) && (rx_lvl <= LVLW'(DEPTH)));

    p_txo_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TXDATA && tx_full) |=> irq_raw[IRQ_TXO]);

    p_rxu_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RXDATA && rx_empty) |=> irq_raw[IRQ_RXU]);

    p_rxo_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full) |=> irq_raw[IRQ_RXO]);

    p_thr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_tx < LVLW'(DEPTH));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_raw != '0));

    p_txo_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw[IRQ_TXO] && !clr_txo_hit) |=> irq_raw[IRQ_TXO]);

    p_dma_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |-> (rx_lvl != '0));

endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .eng_rx_push (eng_rx_push),
    .tx_lvl      (tx_lvl),
    .rx_lvl      (rx_lvl),
    .tx_full     (tx_full),
    .rx_full     (rx_full),
    .rx_empty    (rx_empty),
    .irq_raw     (irq_raw),
    .thr_tx      (thr_tx),
    .irq         (irq),
    .dma_rx_req  (dma_rx_req)
);

// File: tb/spi_fifo_irq_unit_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for queue order, overflow, underflow, clear, DMA, busy and reset.
module spi_fifo_irq_unit_bench;

    localparam int DW    = 16;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          eng_busy = 1'b0;
    logic          eng_tx_pop = 1'b0;
    logic [DW-1:0] eng_tx_data;
    logic          eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic          irq, dma_tx_req, dma_rx_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spi_fifo_irq_unit #(.DW(DW), .DEPTH(DEPTH)) u_spi_fifo_irq_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .eng_busy    (eng_busy),
        .eng_tx_pop  (eng_tx_pop),
        .eng_tx_data (eng_tx_data),
        .eng_rx_push (eng_rx_push),
        .eng_rx_data (eng_rx_data),
        .irq         (irq),
        .dma_tx_req  (dma_tx_req),
        .dma_rx_req  (dma_rx_req)
    );

    // Register addresses as stated in R2
    localparam logic [3:0] TXD = 4'h0, RXD = 4'h1, TXL = 4'h2, RXL = 4'h3,
                           STA = 4'h4, TTH = 4'h5, RTH = 4'h6, MSK = 4'h7,
                           RAW = 4'h8, MSD = 4'h9, CLR = 4'hA, DCT = 4'hB,
                           DTX = 4'hC, DRX = 4'hD;

    // Vector: {op, addr, data, expected, requirement}; op 0 write, 1 peek, 2 pop-read
    localparam int NV = 25;
    localparam logic [41:0] VEC [NV] = '{
        {2'd1, STA, 16'h0000, 16'h000C, 4'd1},   // R1 status after reset
        {2'd1, RAW, 16'h0000, 16'h0001, 4'd1},   // R1 raw after reset
        {2'd1, TXL, 16'h0000, 16'h0000, 4'd1},   // R1 level after reset
        {2'd0, TXD, 16'h00A1, 16'h0000, 4'd2},
        {2'd0, TXD, 16'h00B2, 16'h0000, 4'd2},
        {2'd0, TXD, 16'h00C3, 16'h0000, 4'd2},
        {2'd1, TXL, 16'h0000, 16'h0003, 4'd2},   // R2 transmit level
        {2'd1, STA, 16'h0000, 16'h0008, 4'd3},   // R3 tx not empty
        {2'd1, RAW, 16'h0000, 16'h0000, 4'd7},   // R7 level 3 > thr 0
        {2'd0, TTH, 16'h0004, 16'h0000, 4'd7},
        {2'd1, RAW, 16'h0000, 16'h0001, 4'd7},   // R7 level 3 <= thr 4
        {2'd0, TTH, 16'h0008, 16'h0000, 4'd8},
        {2'd1, TTH, 16'h0000, 16'h0004, 4'd8},   // R8 value DEPTH rejected
        {2'd0, TTH, 16'h0007, 16'h0000, 4'd8},
        {2'd1, TTH, 16'h0000, 16'h0007, 4'd8},   // R8 DEPTH-1 accepted
        {2'd0, MSK, 16'h001F, 16'h0000, 4'd9},
        {2'd1, MSD, 16'h0000, 16'h0001, 4'd9},   // R9 masked view
        {2'd2, RXD, 16'h0000, 16'h0000, 4'd5},   // R5 empty read returns 0
        {2'd1, RAW, 16'h0000, 16'h0005, 4'd5},   // R5 underflow flag
        {2'd1, MSD, 16'h0000, 16'h0005, 4'd9},
        {2'd0, CLR, 16'h0002, 16'h0000, 4'd10},
        {2'd1, RAW, 16'h0000, 16'h0001, 4'd10},  // R10 clear underflow only
        {2'd0, MSK, 16'h0000, 16'h0000, 4'd9},
        {2'd1, MSD, 16'h0000, 16'h0000, 4'd9},
        {2'd0, TTH, 16'h0000, 16'h0000, 4'd7}
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic pop_read(output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = RXD; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic eng_pop(output logic [DW-1:0] d);
        @(negedge clk);
        eng_tx_pop = 1'b1;
        #1 d = eng_tx_data;
        @(posedge clk); #1;
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [DW-1:0] d);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(posedge clk); #1;
        eng_rx_push = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][41:40])
                2'd0: bus_write(VEC[i][39:36], VEC[i][35:20]);
                2'd1: begin
                    peek(VEC[i][39:36], v);
                    check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
                end
                default: begin
                    pop_read(v);
                    check($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
                end
            endcase
        end

        // R2 engine sees transmit words in write order
        eng_pop(v); check("R2 tx order 0", v, 16'h00A1);
        eng_pop(v); check("R2 tx order 1", v, 16'h00B2);
        eng_pop(v); check("R2 tx order 2", v, 16'h00C3);
        peek(TXL, v); check("R2 tx level drained", v, 16'h0000);

        // R3/R4 fill, overflow, stickiness
        for (int k = 0; k < DEPTH; k++) bus_write(TXD, DW'(16'h0100 + k));
        peek(STA, v); check("R3 tx full status", v, 16'h000A);
        bus_write(TXD, 16'hFFFF);
        peek(TXL, v); check("R4 level held at depth", v, DW'(DEPTH));
        peek(RAW, v); check("R4 overflow flag", v, 16'h0002);
        for (int k = 0; k < DEPTH; k++) begin
            eng_pop(v); check("R4 extra word discarded", v, DW'(16'h0100 + k));
        end
        peek(RAW, v); check("R4 overflow sticky after drain", v, 16'h0003);
        bus_write(CLR, 16'h0008);
        peek(RAW, v); check("R10 clear transmit overflow", v, 16'h0001);

        // R6/R7 receive side
        for (int k = 1; k <= DEPTH; k++) eng_push(DW'(16'h0011 * k));
        peek(RXL, v); check("R2 rx level", v, DW'(DEPTH));
        peek(STA, v); check("R3 rx full status", v, 16'h0014);
        peek(RAW, v); check("R7 rx above threshold", v, 16'h0011);
        eng_push(16'hEEEE);
        peek(RAW, v); check("R6 rx overflow flag", v, 16'h0019);
        bus_write(RTH, 16'h0007);
        bus_write(RTH, 16'h0009);
        peek(RTH, v); check("R8 rx threshold keeps old value", v, 16'h0007);
        pop_read(v); check("R2 rx order 0", v, 16'h0011);
        peek(RAW, v); check("R7 rx level at threshold", v, 16'h0009);
        for (int k = 2; k <= DEPTH; k++) begin
            pop_read(v); check("R6 rx order, overflow word dropped", v, DW'(16'h0011 * k));
        end
        peek(RXL, v); check("R2 rx level drained", v, 16'h0000);

        // R9/R10 interrupt line and clear-all
        pop_read(v);
        peek(RAW, v); check("R5 underflow with overflow", v, 16'h000D);
        bus_write(MSK, 16'h0008);
        #1 check("R9 irq from masked overflow", {15'd0, irq}, 16'h0001);
        bus_write(CLR, 16'h0001);
        peek(RAW, v); check("R10 clear all sticky", v, 16'h0001);
        check("R9 irq low after clear", {15'd0, irq}, 16'h0000);
        bus_write(MSK, 16'h0001);
        #1 check("R9 irq from threshold bit", {15'd0, irq}, 16'h0001);
        bus_write(MSK, 16'h0000);

        // R11 DMA requests
        #1 check("R11 tx dma disabled", {15'd0, dma_tx_req}, 16'h0000);
        bus_write(DTX, 16'h0002);
        bus_write(DCT, 16'h0003);
        #1 check("R11 tx dma at low level", {15'd0, dma_tx_req}, 16'h0001);
        check("R11 rx dma idle when empty", {15'd0, dma_rx_req}, 16'h0000);
        for (int k = 0; k < 3; k++) bus_write(TXD, DW'(k));
        #1 check("R11 tx dma above level", {15'd0, dma_tx_req}, 16'h0000);
        bus_write(DRX, 16'h0001);
        eng_push(16'h0AAA);
        eng_push(16'h0BBB);
        #1 check("R11 rx dma above level", {15'd0, dma_rx_req}, 16'h0001);
        pop_read(v);
        #1 check("R11 rx dma at level", {15'd0, dma_rx_req}, 16'h0000);

        // R3 busy bit follows the engine
        eng_busy = 1'b1;
        peek(STA, v); check("R3 busy set", v, 16'h0001);
        eng_busy = 1'b0;
        peek(STA, v); check("R3 busy clear", v, 16'h0000);

        // R1 reset in mid-run
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        peek(TXL, v); check("R1 tx level after reset", v, 16'h0000);
        peek(RXL, v); check("R1 rx level after reset", v, 16'h0000);
        peek(STA, v); check("R1 status after reset", v, 16'h000C);
        peek(RAW, v); check("R1 raw after reset", v, 16'h0001);
        peek(DCT, v); check("R1 dma control after reset", v, 16'h0000);
        peek(DTX, v); check("R1 dma level after reset", v, 16'h0000);
        check("R1 outputs low", {13'd0, irq, dma_tx_req, dma_rx_req}, 16'h0000);

        finish_run();
    end

endmodule